// File: doc/BRIEF.md
# OLED Command and Data Byte Interpreter

This block sits behind the byte-level receiver of a two-wire serial slave that drives a small monochrome OLED panel. Every byte of a write transfer arrives as a one-cycle valid strobe with its data, and a separate one-cycle pulse marks the stop condition. A leading control byte chooses how the following bytes are handled. In data handling, bytes go into a paged display RAM through a one-byte-per-cycle write port. In command handling, a single byte moves the column and page pointers or changes a display flag.

Some commands carry a parameter byte that this block has no use for. These commands arm a pending-skip marker. The next byte that reaches command handling is thrown away and the marker is cleared. The marker survives control bytes and stop conditions. A read request always returns 0xFF.

All state changes and output pulses are registered. The effect of a byte accepted at clock edge k is visible on the ports from edge k until edge k+1 or later.

Top module: `oled_byte_interp`

## Requirements
- R1: In idle handling, byte 0x80 enters command handling and byte 0x40 enters data handling. Any other byte gives a one-cycle `err_ctrl` pulse and changes no pointer, flag or RAM.
- R2: In data handling with column below 132, the byte is written with `ram_we` high for one cycle at `ram_addr` = column + page*132. The column then rises by one and `redraw` is set.
- R3: In data handling with column 132 or above, the byte is dropped: no write and no column change.
- R4: Data handling lasts for every byte until the stop pulse. After the stop pulse the block is idle, so the next byte is taken as a control byte.
- R5: After one command byte is executed, the block returns to idle handling.
- R6: Commands 0x00–0x0F replace the column's low nibble with the command's low nibble. Commands 0x10–0x20 replace the column's high nibble with the command's low nibble.
- R7: Commands 0xB0–0xBF set the page to bits [2:0] of the command. Commands 0x40–0x7F set the start line to zero.
- R8: The flag commands work in pairs, where the even code clears and the odd code sets: 0xA0/0xA1 for `mirror`, 0xA4/0xA5 for `all_on`, 0xA6/0xA7 for `inverse`, and 0xAE/0xAF for `enable`.
- R9: Commands 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB arm a pending skip. The next byte received in command handling is discarded with no effect and clears the skip, and the block stays in command handling. The pending skip survives control bytes and stop pulses.
- R10: Commands 0xC0–0xC8 and 0xE3 have no effect. Every other command gives a one-cycle `err_cmd` pulse and no state change.
- R11: While `rd_req` is high, `rd_data` is 0xFF; otherwise it is 0x00.
- R12: Reset clears the column, page, start line and all four flags, and leaves the block idle with no pending skip and `redraw` set. `redraw_ack` clears `redraw` unless a RAM write happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_stop | input | 1 | End-of-transfer pulse |
| rd_req | input | 1 | Read byte request |
| rd_data | output | 8 | Read byte value |
| redraw_ack | input | 1 | Clears the redraw flag |
| ram_we | output | 1 | Display RAM write enable |
| ram_addr | output | 11 | Display RAM byte address |
| ram_wdata | output | 8 | Display RAM write byte |
| col | output | 8 | Column pointer |
| page | output | 3 | Page pointer |
| start_line | output | 6 | Display start line |
| mirror | output | 1 | Horizontal mirror flag |
| all_on | output | 1 | Entire-display-on flag |
| inverse | output | 1 | Inverse video flag |
| enable | output | 1 | Display enable flag |
| redraw | output | 1 | Display content changed |
| err_ctrl | output | 1 | Bad control byte pulse |
| err_cmd | output | 1 | Unknown command pulse |

## Verification
Assertions check the following on every cycle:
- each write advances the column by one and leaves `redraw` set;
- write addresses stay inside the RAM;
- a byte at column 132 or above causes no write;
- an executed command returns the block to idle;
- data handling holds until the stop pulse;
- a discarded parameter clears the skip;
- `err_cmd` never lasts two cycles.

Only the bench's scenarios can show the rest. This covers the decoding of each of the 256 command codes, the RAM address formula over all pages, and that a pending skip survives control bytes and stops. The bench compares all outputs against a byte-level model after every byte.

// File: rtl/oled_interp_pkg.sv
package oled_interp_pkg;

    typedef enum logic [1:0] {M_IDLE, M_DATA, M_CMD} mode_e;

    typedef enum logic [2:0] {
        OP_COL_LO, OP_COL_HI, OP_START, OP_PAGE,
        OP_FLAG, OP_SKIP, OP_NOP, OP_BAD
    } op_e;

    typedef enum logic [1:0] {FL_MIRROR, FL_ALLON, FL_INVERT, FL_ENABLE} flag_e;

    typedef struct packed {
        op_e        op;
        flag_e      flag;
        logic       val;
        logic [3:0] nib;
    } cmd_t;

    typedef struct packed {
        logic mirror;
        logic all_on;
        logic inverse;
        logic enable;
    } flags_t;

    localparam logic [7:0] CTRL_CMD  = 8'h80;
    localparam logic [7:0] CTRL_DATA = 8'h40;
    localparam logic [7:0] READ_VAL  = 8'hFF;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.op   = OP_BAD;
        c.flag = FL_MIRROR;
        c.val  = b[0];
        c.nib  = b[3:0];
        if (b <= 8'h0F)                     c.op = OP_COL_LO;
        else if (b <= 8'h20)                c.op = OP_COL_HI;
        else if (b >= 8'h40 && b <= 8'h7F)  c.op = OP_START;
        else if (b >= 8'hB0 && b <= 8'hBF)  c.op = OP_PAGE;
        else if (b >= 8'hC0 && b <= 8'hC8)  c.op = OP_NOP;
        else begin
            case (b)
                8'hA0, 8'hA1: begin c.op = OP_FLAG; c.flag = FL_MIRROR; end
                8'hA4, 8'hA5: begin c.op = OP_FLAG; c.flag = FL_ALLON;  end
                8'hA6, 8'hA7: begin c.op = OP_FLAG; c.flag = FL_INVERT; end
                8'hAE, 8'hAF: begin c.op = OP_FLAG; c.flag = FL_ENABLE; end
                8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
                8'hD8, 8'hD9, 8'hDA, 8'hDB: c.op = OP_SKIP;
                8'hE3:                      c.op = OP_NOP;
                default:                    c.op = OP_BAD;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/oled_cmd_decode.sv
module oled_cmd_decode
    import oled_interp_pkg::*;
(
    input  logic [7:0] byte_in,
    output cmd_t       cmd
);
    always_comb cmd = decode_cmd(byte_in);
endmodule

// File: rtl/oled_mode_fsm.sv
module oled_mode_fsm
    import oled_interp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_stop,
    input  logic       arm_skip,
    output logic       cmd_fire,
    output logic       data_fire,
    output logic       err_ctrl
);
    mode_e mode_q, mode_d;
    logic  skip_q, skip_d;

    assign cmd_fire  = rx_valid && mode_q == M_CMD && !skip_q;
    assign data_fire = rx_valid && mode_q == M_DATA;

    always_comb begin
        mode_d = mode_q;
        skip_d = skip_q;
        if (rx_valid) begin
            unique case (mode_q)
                M_IDLE: begin
                    if (rx_data == CTRL_CMD)       mode_d = M_CMD;
                    else if (rx_data == CTRL_DATA) mode_d = M_DATA;
                end
                M_DATA: mode_d = M_DATA;
                M_CMD: begin
                    if (skip_q) begin
                        skip_d = 1'b0;        // parameter dropped, still in command handling
                    end else begin
                        mode_d = M_IDLE;
                        skip_d = arm_skip;
                    end
                end
                default: mode_d = M_IDLE;
            endcase
        end
        if (rx_stop) mode_d = M_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= M_IDLE;
            skip_q   <= 1'b0;
            err_ctrl <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            skip_q   <= skip_d;
            err_ctrl <= rx_valid && mode_q == M_IDLE &&
                        rx_data != CTRL_CMD && rx_data != CTRL_DATA;
        end
    end

    a_r5_cmd_to_idle: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |=> mode_q == M_IDLE);
    a_r4_data_holds: assert property (@(posedge clk) disable iff (rst)
        mode_q == M_DATA && !rx_stop |=> mode_q == M_DATA);
    a_r9_skip_clears: assert property (@(posedge clk) disable iff (rst)
        rx_valid && mode_q == M_CMD && skip_q |=> !skip_q && mode_q == M_CMD || $past(rx_stop));
endmodule

// File: rtl/oled_disp_state.sv
module oled_disp_state
    import oled_interp_pkg::*;
#(
    parameter int COLS  = 132,
    parameter int PAGES = 8,
    parameter int LINES = 64,
    localparam int PG_W   = $clog2(PAGES),
    localparam int SL_W   = $clog2(LINES),
    localparam int ADDR_W = $clog2(COLS * PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_fire,
    input  cmd_t              cmd,
    input  logic              data_fire,
    input  logic [7:0]        data_in,
    input  logic              redraw_ack,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic [7:0]        col,
    output logic [PG_W-1:0]   page,
    output logic [SL_W-1:0]   start_line,
    output flags_t            flags,
    output logic              redraw,
    output logic              err_cmd
);
    logic col_ok, do_write;
    assign col_ok   = int'(col) < COLS;
    assign do_write = data_fire && col_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            col        <= '0;
            page       <= '0;
            start_line <= '0;
            flags      <= '0;
            redraw     <= 1'b1;
            ram_we     <= 1'b0;
            ram_addr   <= '0;
            ram_wdata  <= '0;
            err_cmd    <= 1'b0;
        end else begin
            ram_we  <= do_write;
            err_cmd <= cmd_fire && cmd.op == OP_BAD;
            if (redraw_ack) redraw <= 1'b0;
            if (do_write) begin
                ram_addr  <= ADDR_W'(int'(col) + int'(page) * COLS);
                ram_wdata <= data_in;
                col       <= col + 8'd1;
                redraw    <= 1'b1;
            end
            if (cmd_fire) begin
                unique case (cmd.op)
                    OP_COL_LO: col[3:0]   <= cmd.nib;
                    OP_COL_HI: col[7:4]   <= cmd.nib;
                    OP_START:  start_line <= '0;
                    OP_PAGE:   page       <= cmd.nib[PG_W-1:0];
                    OP_FLAG: begin
                        unique case (cmd.flag)
                            FL_MIRROR: flags.mirror  <= cmd.val;
                            FL_ALLON:  flags.all_on  <= cmd.val;
                            FL_INVERT: flags.inverse <= cmd.val;
                            FL_ENABLE: flags.enable  <= cmd.val;
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r2_write_advances: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> col == $past(col) + 8'd1);
    a_r2_write_redraw: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> redraw);
    a_r3_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> int'(ram_addr) < COLS * PAGES);
    a_r3_drop_past_end: assert property (@(posedge clk) disable iff (rst)
        data_fire && !col_ok |=> !ram_we && $stable(col));
    a_r10_err_single: assert property (@(posedge clk) disable iff (rst)
        err_cmd |=> !err_cmd);
endmodule

// File: rtl/oled_byte_interp.sv
module oled_byte_interp
    import oled_interp_pkg::*;
#(
    parameter int COLS  = 132,
    parameter int PAGES = 8,
    parameter int LINES = 64,
    localparam int PG_W   = $clog2(PAGES),
    localparam int SL_W   = $clog2(LINES),
    localparam int ADDR_W = $clog2(COLS * PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_stop,
    input  logic              rd_req,
    output logic [7:0]        rd_data,
    input  logic              redraw_ack,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic [7:0]        col,
    output logic [PG_W-1:0]   page,
    output logic [SL_W-1:0]   start_line,
    output logic              mirror,
    output logic              all_on,
    output logic              inverse,
    output logic              enable,
    output logic              redraw,
    output logic              err_ctrl,
    output logic              err_cmd
);
    cmd_t   cmd;
    flags_t flags;
    logic   cmd_fire, data_fire;

    assign rd_data = rd_req ? READ_VAL : 8'h00;

    oled_cmd_decode u_dec (
        .byte_in (rx_data),
        .cmd     (cmd)
    );

    oled_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_stop   (rx_stop),
        .arm_skip  (cmd.op == OP_SKIP),
        .cmd_fire  (cmd_fire),
        .data_fire (data_fire),
        .err_ctrl  (err_ctrl)
    );

    oled_disp_state #(.COLS(COLS), .PAGES(PAGES), .LINES(LINES)) u_state (
        .clk        (clk),
        .rst        (rst),
        .cmd_fire   (cmd_fire),
        .cmd        (cmd),
        .data_fire  (data_fire),
        .data_in    (rx_data),
        .redraw_ack (redraw_ack),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .col        (col),
        .page       (page),
        .start_line (start_line),
        .flags      (flags),
        .redraw     (redraw),
        .err_cmd    (err_cmd)
    );

    assign mirror  = flags.mirror;
    assign all_on  = flags.all_on;
    assign inverse = flags.inverse;
    assign enable  = flags.enable;
endmodule

// File: tb/tb_oled_byte_interp.sv
`timescale 1ns/1ps
module tb_oled_byte_interp;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, rx_valid = 1'b0, rx_stop = 1'b0, rd_req = 1'b0, redraw_ack = 1'b0;
    logic [7:0] rx_data = '0;
    logic [7:0] rd_data, ram_wdata, col;
    logic [10:0] ram_addr;
    logic [2:0] page;
    logic [5:0] start_line;
    logic ram_we, mirror, all_on, inverse, enable, redraw, err_ctrl, err_cmd;

    oled_byte_interp dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_stop(rx_stop),
        .rd_req(rd_req), .rd_data(rd_data), .redraw_ack(redraw_ack),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .col(col), .page(page), .start_line(start_line),
        .mirror(mirror), .all_on(all_on), .inverse(inverse), .enable(enable),
        .redraw(redraw), .err_ctrl(err_ctrl), .err_cmd(err_cmd)
    );

    int checks = 0, errors = 0;
    string tag;

    // byte-level model: 0 idle, 1 data, 2 command
    int m_mode;
    logic m_skip;
    logic [7:0] m_col;
    logic [2:0] m_page;
    logic [5:0] m_sl;
    logic [3:0] m_fl; // mirror, all_on, inverse, enable
    logic m_redraw, e_we, e_ec, e_eu;
    logic [10:0] e_addr;
    logic [7:0] e_wd;

    task automatic model_reset();
        m_mode = 0; m_skip = 0; m_col = 0; m_page = 0; m_sl = 0; m_fl = 0;
        m_redraw = 1; e_we = 0; e_ec = 0; e_eu = 0; e_addr = 0; e_wd = 0;
    endtask

    task automatic model_cmd(input logic [7:0] b);
        tag = "R10";
        if (b <= 8'h0F) begin m_col[3:0] = b[3:0]; tag = "R6"; end
        else if (b <= 8'h20) begin m_col[7:4] = b[3:0]; tag = "R6"; end
        else if (b >= 8'h40 && b <= 8'h7F) begin m_sl = 0; tag = "R7"; end
        else if (b >= 8'hB0 && b <= 8'hBF) begin m_page = b[2:0]; tag = "R7"; end
        else if (b >= 8'hC0 && b <= 8'hC8) tag = "R10";
        else if (b == 8'hE3) tag = "R10";
        else if (b == 8'hA0 || b == 8'hA1) begin m_fl[3] = b[0]; tag = "R8"; end
        else if (b == 8'hA4 || b == 8'hA5) begin m_fl[2] = b[0]; tag = "R8"; end
        else if (b == 8'hA6 || b == 8'hA7) begin m_fl[1] = b[0]; tag = "R8"; end
        else if (b == 8'hAE || b == 8'hAF) begin m_fl[0] = b[0]; tag = "R8"; end
        else if (b == 8'h81 || b == 8'hA8 || b == 8'hAD || b == 8'hD3 || b == 8'hD5 ||
                 b == 8'hD8 || b == 8'hD9 || b == 8'hDA || b == 8'hDB) begin
            m_skip = 1; tag = "R9";
        end else e_eu = 1;
    endtask

    task automatic model_byte(input logic [7:0] b);
        e_we = 0; e_ec = 0; e_eu = 0;
        case (m_mode)
            0: begin
                tag = "R1";
                if (b == 8'h80) m_mode = 2;
                else if (b == 8'h40) m_mode = 1;
                else e_ec = 1;
            end
            1: begin
                if (m_col < 8'd132) begin
                    tag = "R2"; e_we = 1; e_wd = b;
                    e_addr = 11'(int'(m_col) + int'(m_page) * 132);
                    m_col = m_col + 1; m_redraw = 1;
                end else tag = "R3";
            end
            default: begin
                if (m_skip) begin m_skip = 0; tag = "R9"; end
                else begin m_mode = 0; model_cmd(b); end
            end
        endcase
    endtask

    task automatic compare();
        logic [43:0] act, exp;
        act = {col, page, start_line, mirror, all_on, inverse, enable, redraw,
               ram_we, ram_we ? ram_addr : 11'd0, ram_we ? ram_wdata : 8'd0, err_ctrl, err_cmd};
        exp = {m_col, m_page, m_sl, m_fl, m_redraw,
               e_we, e_we ? e_addr : 11'd0, e_we ? e_wd : 8'd0, e_ec, e_eu};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        rx_valid = 1; rx_data = b;
        model_byte(b);
        @(negedge clk);
        rx_valid = 0;
        compare();
    endtask

    task automatic stop();
        rx_stop = 1; e_we = 0; e_ec = 0; e_eu = 0; m_mode = 0; tag = "R4";
        @(negedge clk);
        rx_stop = 0;
        compare();
    endtask

    task automatic ack();
        redraw_ack = 1; e_we = 0; e_ec = 0; e_eu = 0; m_redraw = 0; tag = "R12";
        @(negedge clk);
        redraw_ack = 0;
        compare();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        tag = "R12"; e_we = 0; compare();          // R12 reset state
        ack();                                      // R12 redraw cleared

        // R11 read value
        rd_req = 1; #1;
        checks++;
        if (rd_data !== 8'hFF) begin errors++; $display("FAIL R11 actual=%h expected=ff", rd_data); end
        rd_req = 0; #1;
        checks++;
        if (rd_data !== 8'h00) begin errors++; $display("FAIL R11 actual=%h expected=00", rd_data); end
        @(negedge clk);

        // R1 bad control bytes, back to back
        send(8'h55); send(8'h00); send(8'hFF);

        // R6..R10, R5: every command code, followed by a parameter or a nop
        for (int c = 0; c < 256; c++) begin
            send(8'h80);
            send(8'(c));
            if (m_skip) begin send(8'h80); send(8'hAF); end // R9 parameter discarded
            if (m_mode == 2) send(8'hE3);
            send(8'h80); send(8'h07);                       // R5 next byte is control
            if (c % 16 == 0) stop();
        end

        // R9 skip survives control bytes and a stop
        send(8'h80); send(8'hA6);
        send(8'h80); send(8'hD5);
        stop();
        send(8'h80); send(8'hA7);   // discarded: inverse stays 0
        send(8'hA7);                // still command handling: inverse set
        stop();

        // R2/R3 data near the end of a row, then drop past it
        send(8'h80); send(8'hB3);
        send(8'h80); send(8'h18);
        send(8'h80); send(8'h02);
        send(8'h40);
        for (int i = 0; i < 5; i++) send(8'(8'hC0 + i));
        stop();
        send(8'hAA);                // R4 after stop: control byte, bad -> err_ctrl
        ack();

        // R2 address sweep over every page
        for (int p = 0; p < 8; p++) begin
            send(8'h80); send(8'(8'hB0 + p));
            send(8'h80); send(8'(8'h10 + (p % 8)));
            send(8'h80); send(8'(p * 2));
            send(8'h40);
            for (int k = 0; k < 6; k++) send(8'(p * 16 + k));
            send(8'h80);            // R4 still data handling: written as data
            stop();
        end

        // R12 reset mid-stream restores reset values
        send(8'h80); send(8'hA5);
        rst = 1; @(negedge clk); rst = 0;
        model_reset(); tag = "R12";
        @(negedge clk); compare();
        send(8'h40);                // idle after reset: enters data handling
        send(8'h11);
        finish_run();
    end
endmodule